// File: doc/BRIEF.md
# PHY Serial-Mode Data Bus Multiplexer

This block sits on the transceiver side of an 8-bit link data bus. It decides who drives each bus pin and what each pin means. There are four bus modes. In normal mode every pin is released to the packet-level protocol engine, which is outside this block. In low-power mode the transceiver reports the receiver line state and an interrupt flag. In two legacy full/low-speed serial modes, a six-pin mode and a three-pin mode, the link drives transmit controls in and the transceiver drives receive signals out.

A configuration write from the normal mode selects a serial mode and says whether the interface clock keeps running. A low-power request enters low-power mode. The stop strobe from the link returns any non-normal mode to the normal bus definition. On every mode change all pins are released for one cycle, so the link and the transceiver never drive the same pin at once. Transmit controls are passed to the line driver only while a serial mode is settled.

Top module: `phy_serial_busmux`

## Requirements
- R1: While `rst` is high and in the cycle after it, `mode_o` is 0 (normal), `bus_oe` is all zero, the three transmit outputs are 0 and `clk_run_o` is 1.
- R2: `mode_o` codes are normal=0, low-power=1, six-pin=2, three-pin=3. From normal, `lp_req` moves to low-power at the next edge. In any non-normal mode, `stp` high at an edge returns to normal.
- R3: A `cfg_wr` in normal mode with `cfg_wdata` bit 0 set enters six-pin mode, and with only bit 1 set enters three-pin mode. When both bits are set, six-pin mode wins. A write with neither bit set, and any write or `lp_req` while not in normal mode, leaves the mode unchanged. A write takes priority over `lp_req` in the same cycle.
- R4: In the first cycle after any mode change, `bus_oe` is all zero and all three transmit outputs are 0.
- R5: In settled low-power mode `bus_oe` is all ones. `bus_out` bits 1:0 follow `line_state` combinationally, with no register, bit 3 equals `irq_pending`, and all other bits are 0.
- R6: In settled six-pin mode `bus_oe` is 8'hF8. Bit 3 carries `irq_pending`, bit 4 `rx_dp`, bit 5 `rx_dm`, bit 6 `rx_rcv` and bit 7 is 0. `tx_en_o`, `tx_dat_o` and `tx_se0_o` follow `bus_in` bits 0, 1 and 2.
- R7: In settled three-pin mode pins 0 and 2 are inputs. Bit 3 carries `irq_pending`, and bits 7:4 are driven 0. Pin 1 is an output carrying `rx_rcv` while `bus_in[0]` is 0, which gives `bus_oe`=8'hFA. It is an input while `bus_in[0]` is 1 (`bus_oe`=8'hF8). `tx_en_o`=`bus_in[0]`, `tx_dat_o`=`bus_in[1]` gated by `bus_in[0]`, and `tx_se0_o`=`bus_in[2]`.
- R8: In normal mode `bus_oe` is all zero and all transmit outputs are 0.
- R9: `clk_run_o` is 1 in normal mode and 0 in low-power mode. In a serial mode it equals `cfg_wdata` bit 3 of the write that entered that mode.
- R10: `stp` in normal mode has no effect on `mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Interface-control write strobe |
| cfg_wdata | input | CFG_W | Write data: bit 0 six-pin, bit 1 three-pin, bit 3 keep clock |
| lp_req | input | 1 | Request to enter low-power mode |
| stp | input | 1 | Stop strobe from the link |
| bus_in | input | BUS_W | Values the link drives on the data bus |
| bus_out | output | BUS_W | Values the transceiver drives on the data bus |
| bus_oe | output | BUS_W | Per-pin output enable of the transceiver |
| line_state | input | 2 | Receiver comparator line state |
| irq_pending | input | 1 | Any unmasked interrupt pending |
| rx_dp | input | 1 | Single-ended receive on DP |
| rx_dm | input | 1 | Single-ended receive on DM |
| rx_rcv | input | 1 | Differential receive data |
| tx_en_o | output | 1 | Transmit enable to line driver |
| tx_dat_o | output | 1 | Differential transmit data to line driver |
| tx_se0_o | output | 1 | Force single-ended zero to line driver |
| clk_run_o | output | 1 | Interface clock enable |
| mode_o | output | 2 | Current bus mode |

## Verification
The bench sets both serial bits in one write. A design with the priority reversed lands in three-pin mode and shows the wrong output-enable mask. It checks the release cycle after every entry and exit. A design without the turnaround drives pins in the very cycle the link may still own them. It toggles the three-pin transmit enable to catch a shared pin 1 that stays driven while the link sends data. It also sends writes, low-power requests and stop strobes in modes where they must be ignored. A design that obeys them changes `mode_o` when it should not, or loses the clock-keep setting.

// File: rtl/busmux_pkg.sv
package busmux_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_LOWPWR = 2'd1,
    MODE_SER6   = 2'd2,
    MODE_SER3   = 2'd3
  } bus_mode_e;

  typedef enum logic [1:0] {
    PIN_IN,
    PIN_OUT,
    PIN_SHARED
  } pin_dir_e;

  typedef enum logic [2:0] {
    SRC_LOW,
    SRC_LS0,
    SRC_LS1,
    SRC_IRQ,
    SRC_DP,
    SRC_DM,
    SRC_RCV
  } pin_src_e;

  // Pin roles on the serial buses
  localparam int PIN_TXEN = 0;
  localparam int PIN_TXDAT = 1;
  localparam int PIN_SE0 = 2;
  localparam int PIN_IRQ = 3;
  localparam int PIN_RXDP = 4;
  localparam int PIN_RXDM = 5;
  localparam int PIN_RXRCV = 6;

  function automatic pin_dir_e pin_dir(bus_mode_e m, int idx);
    pin_dir_e d;
    unique case (m)
      MODE_NORMAL: d = PIN_IN;
      MODE_LOWPWR: d = PIN_OUT;
      MODE_SER6:   d = (idx <= PIN_SE0) ? PIN_IN : PIN_OUT;
      MODE_SER3: begin
        if (idx == PIN_TXDAT) d = PIN_SHARED;
        else if (idx == PIN_TXEN || idx == PIN_SE0) d = PIN_IN;
        else d = PIN_OUT;
      end
      default: d = PIN_IN;
    endcase
    return d;
  endfunction

  function automatic pin_src_e pin_src(bus_mode_e m, int idx);
    pin_src_e s;
    s = SRC_LOW;
    unique case (m)
      MODE_LOWPWR: begin
        if (idx == 0) s = SRC_LS0;
        else if (idx == 1) s = SRC_LS1;
        else if (idx == PIN_IRQ) s = SRC_IRQ;
      end
      MODE_SER6: begin
        if (idx == PIN_IRQ) s = SRC_IRQ;
        else if (idx == PIN_RXDP) s = SRC_DP;
        else if (idx == PIN_RXDM) s = SRC_DM;
        else if (idx == PIN_RXRCV) s = SRC_RCV;
      end
      MODE_SER3: begin
        if (idx == PIN_IRQ) s = SRC_IRQ;
        else if (idx == PIN_TXDAT) s = SRC_RCV;
      end
      default: s = SRC_LOW;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/busmux_mode_fsm.sv
module busmux_mode_fsm
  import busmux_pkg::*;
#(
  parameter int CFG_W     = 8,
  parameter int SIX_BIT   = 0,
  parameter int THREE_BIT = 1,
  parameter int KEEP_BIT  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             lp_req,
  input  logic             stp,
  output bus_mode_e        mode_q,
  output logic             turn_q,
  output logic             clk_run_q
);

  bus_mode_e mode_d;
  logic      keep_q, keep_d;
  logic      want_six, want_three;

  assign want_six   = cfg_wr && cfg_wdata[SIX_BIT];
  assign want_three = cfg_wr && cfg_wdata[THREE_BIT];

  always_comb begin
    mode_d = mode_q;
    keep_d = keep_q;
    unique case (mode_q)
      MODE_NORMAL: begin
        if (want_six) begin
          mode_d = MODE_SER6;
          keep_d = cfg_wdata[KEEP_BIT];
        end else if (want_three) begin
          mode_d = MODE_SER3;
          keep_d = cfg_wdata[KEEP_BIT];
        end else if (lp_req) begin
          mode_d = MODE_LOWPWR;
        end
      end
      default: begin
        if (stp) mode_d = MODE_NORMAL;
      end
    endcase
  end

  function automatic logic run_for(bus_mode_e m, logic keep);
    logic r;
    unique case (m)
      MODE_NORMAL: r = 1'b1;
      MODE_LOWPWR: r = 1'b0;
      default:     r = keep;
    endcase
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_NORMAL;
      turn_q    <= 1'b0;
      keep_q    <= 1'b0;
      clk_run_q <= 1'b1;
    end else begin
      mode_q    <= mode_d;
      turn_q    <= (mode_d != mode_q);
      keep_q    <= keep_d;
      clk_run_q <= run_for(mode_d, keep_d);
    end
  end

endmodule

// File: rtl/busmux_pin_mux.sv
module busmux_pin_mux
  import busmux_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  bus_mode_e        mode,
  input  logic             turn,
  input  logic             link_txen,
  input  logic [1:0]       line_state,
  input  logic             irq_pending,
  input  logic             rx_dp,
  input  logic             rx_dm,
  input  logic             rx_rcv,
  output logic [BUS_W-1:0] bus_out,
  output logic [BUS_W-1:0] bus_oe
);

  for (genvar i = 0; i < BUS_W; i++) begin : g_pin
    pin_dir_e dir;
    pin_src_e src;
    logic     val;
    logic     oe;

    always_comb begin
      dir = pin_dir(mode, i);
      src = pin_src(mode, i);
      unique case (src)
        SRC_LS0: val = line_state[0];
        SRC_LS1: val = line_state[1];
        SRC_IRQ: val = irq_pending;
        SRC_DP:  val = rx_dp;
        SRC_DM:  val = rx_dm;
        SRC_RCV: val = rx_rcv;
        default: val = 1'b0;
      endcase
      oe = !turn && ((dir == PIN_OUT) || (dir == PIN_SHARED && !link_txen));
    end

    assign bus_oe[i]  = oe;
    assign bus_out[i] = oe & val;
  end

endmodule

// File: rtl/busmux_tx_path.sv
module busmux_tx_path
  import busmux_pkg::*;
(
  input  bus_mode_e  mode,
  input  logic       turn,
  input  logic [2:0] link_ctl,
  output logic       tx_en,
  output logic       tx_dat,
  output logic       tx_se0
);

  logic active;

  assign active = !turn && (mode == MODE_SER6 || mode == MODE_SER3);

  always_comb begin
    tx_en  = active & link_ctl[PIN_TXEN];
    tx_se0 = active & link_ctl[PIN_SE0];
    if (mode == MODE_SER3)
      tx_dat = active & link_ctl[PIN_TXEN] & link_ctl[PIN_TXDAT];
    else
      tx_dat = active & link_ctl[PIN_TXDAT];
  end

endmodule

// File: rtl/phy_serial_busmux.sv
module phy_serial_busmux
  import busmux_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int CFG_W     = 8,
  parameter int SIX_BIT   = 0,
  parameter int THREE_BIT = 1,
  parameter int KEEP_BIT  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             lp_req,
  input  logic             stp,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] bus_out,
  output logic [BUS_W-1:0] bus_oe,
  input  logic [1:0]       line_state,
  input  logic             irq_pending,
  input  logic             rx_dp,
  input  logic             rx_dm,
  input  logic             rx_rcv,
  output logic             tx_en_o,
  output logic             tx_dat_o,
  output logic             tx_se0_o,
  output logic             clk_run_o,
  output logic [1:0]       mode_o
);

  localparam int CTL_W = PIN_SE0 + 1;

  bus_mode_e mode;
  logic      turn;
  logic      unused_bus_hi;

  assign unused_bus_hi = ^bus_in[BUS_W-1:CTL_W];

  busmux_mode_fsm #(
    .CFG_W    (CFG_W),
    .SIX_BIT  (SIX_BIT),
    .THREE_BIT(THREE_BIT),
    .KEEP_BIT (KEEP_BIT)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_wdata(cfg_wdata),
    .lp_req   (lp_req),
    .stp      (stp),
    .mode_q   (mode),
    .turn_q   (turn),
    .clk_run_q(clk_run_o)
  );

  busmux_pin_mux #(
    .BUS_W(BUS_W)
  ) u_pins (
    .mode       (mode),
    .turn       (turn),
    .link_txen  (bus_in[PIN_TXEN]),
    .line_state (line_state),
    .irq_pending(irq_pending),
    .rx_dp      (rx_dp),
    .rx_dm      (rx_dm),
    .rx_rcv     (rx_rcv),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe)
  );

  busmux_tx_path u_tx (
    .mode    (mode),
    .turn    (turn),
    .link_ctl(bus_in[CTL_W-1:0]),
    .tx_en   (tx_en_o),
    .tx_dat  (tx_dat_o),
    .tx_se0  (tx_se0_o)
  );

  assign mode_o = mode;

endmodule

// File: rtl/busmux_chk.sv
module busmux_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             stp,
  input logic [1:0]       mode_o,
  input logic [BUS_W-1:0] bus_oe,
  input logic [BUS_W-1:0] bus_out,
  input logic [1:0]       line_state,
  input logic             irq_pending,
  input logic             tx_en_o,
  input logic             clk_run_o
);

  localparam logic [BUS_W-1:0] SER_MASK = {{(BUS_W-3){1'b1}}, 3'b000};

  a_r8_normal_released: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd0) |-> (bus_oe == '0 && !tx_en_o));

  a_r4_turnaround: assert property (@(posedge clk) disable iff (rst)
    (mode_o != $past(mode_o)) |-> (bus_oe == '0 && !tx_en_o));

  a_r2_stp_exit: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 2'd0 && stp) |=> (mode_o == 2'd0));

  a_r3_no_jump_between_modes: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_o) != 2'd0 && mode_o != 2'd0) |-> (mode_o == $past(mode_o)));

  a_r5_lowpower_map: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd1 && bus_oe != '0) |->
      (bus_out[1:0] == line_state && bus_out[3] == irq_pending &&
       !bus_out[2] && bus_out[BUS_W-1:4] == '0));

  a_r6_six_pin_dirs: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2 && $past(mode_o) == 2'd2) |-> (bus_oe == SER_MASK));

  a_r9_lowpower_clock: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd1) |-> !clk_run_o);

endmodule

bind phy_serial_busmux busmux_chk #(.BUS_W(BUS_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stp        (stp),
  .mode_o     (mode_o),
  .bus_oe     (bus_oe),
  .bus_out    (bus_out),
  .line_state (line_state),
  .irq_pending(irq_pending),
  .tx_en_o    (tx_en_o),
  .clk_run_o  (clk_run_o)
);

// File: tb/phy_serial_busmux_tb.sv
module phy_serial_busmux_tb;

  localparam int PERIOD = 10;

  typedef struct {
    logic [1:0] mode;
    logic [7:0] oe;
    logic [7:0] dout;
    logic       en;
    logic       dat;
    logic       se0;
    logic       run;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       lp_req = 1'b0;
  logic       stp = 1'b0;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out, bus_oe;
  logic [1:0] line_state = '0;
  logic       irq_pending = 1'b0;
  logic       rx_dp = 1'b0, rx_dm = 1'b0, rx_rcv = 1'b0;
  logic       tx_en_o, tx_dat_o, tx_se0_o, clk_run_o;
  logic [1:0] mode_o;

  int tests = 0;
  int fails = 0;
  exp_t q[$];

  logic [1:0] m_mode = 2'd0;
  logic       m_turn = 1'b0;
  logic       m_keep = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  phy_serial_busmux u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .lp_req(lp_req), .stp(stp), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .line_state(line_state), .irq_pending(irq_pending),
    .rx_dp(rx_dp), .rx_dm(rx_dm), .rx_rcv(rx_rcv), .tx_en_o(tx_en_o),
    .tx_dat_o(tx_dat_o), .tx_se0_o(tx_se0_o), .clk_run_o(clk_run_o),
    .mode_o(mode_o)
  );

  // Driver: advance the requirement model, queue the expected result, clock it.
  task automatic step(input string tag);
    exp_t e;
    logic [1:0] nm;
    if (rst) begin
      m_mode = 2'd0; m_turn = 1'b0; m_keep = 1'b0;
    end else begin
      nm = m_mode;
      if (m_mode == 2'd0) begin
        if (cfg_wr && cfg_wdata[0]) begin nm = 2'd2; m_keep = cfg_wdata[3]; end
        else if (cfg_wr && cfg_wdata[1]) begin nm = 2'd3; m_keep = cfg_wdata[3]; end
        else if (lp_req) nm = 2'd1;
      end else if (stp) nm = 2'd0;
      m_turn = (nm != m_mode);
      m_mode = nm;
    end
    e.mode = m_mode; e.tag = tag;
    e.oe = '0; e.dout = '0; e.en = 1'b0; e.dat = 1'b0; e.se0 = 1'b0;
    if (!m_turn) begin
      case (m_mode)
        2'd1: begin
          e.oe = 8'hFF;
          e.dout = {4'b0, irq_pending, 1'b0, line_state};
        end
        2'd2: begin
          e.oe = 8'hF8;
          e.dout = {1'b0, rx_rcv, rx_dm, rx_dp, irq_pending, 3'b0};
          e.en = bus_in[0]; e.dat = bus_in[1]; e.se0 = bus_in[2];
        end
        2'd3: begin
          e.oe = bus_in[0] ? 8'hF8 : 8'hFA;
          e.dout = {4'b0, irq_pending, 1'b0, (bus_in[0] ? 1'b0 : rx_rcv), 1'b0};
          e.en = bus_in[0]; e.dat = bus_in[0] & bus_in[1]; e.se0 = bus_in[2];
        end
        default: ;
      endcase
    end
    e.run = (m_mode == 2'd0) ? 1'b1 : (m_mode == 2'd1) ? 1'b0 : m_keep;
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  // Monitor: compare after each edge, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        tests++;
        if (mode_o !== e.mode || bus_oe !== e.oe || (bus_out & bus_oe) !== e.dout ||
            tx_en_o !== e.en || tx_dat_o !== e.dat || tx_se0_o !== e.se0 ||
            clk_run_o !== e.run) begin
          fails++;
          $display("FAIL %s: got mode=%0d oe=%h out=%h tx=%b%b%b run=%b, expected mode=%0d oe=%h out=%h tx=%b%b%b run=%b",
                   e.tag, mode_o, bus_oe, bus_out & bus_oe, tx_en_o, tx_dat_o, tx_se0_o, clk_run_o,
                   e.mode, e.oe, e.dout, e.en, e.dat, e.se0, e.run);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    step("R1 reset held");
    step("R1 reset held");
    rst = 1'b0;
    step("R1 state after reset");

    stp = 1'b1; step("R10 stp ignored in normal");
    stp = 1'b0; step("R8 normal idle");

    lp_req = 1'b1; step("R2 R4 enter low-power, release cycle");
    lp_req = 1'b0; line_state = 2'b01; step("R5 low-power settled");
    line_state = 2'b10; irq_pending = 1'b1; step("R5 linestate and irq");
    cfg_wr = 1'b1; cfg_wdata = 8'h09; step("R3 write ignored in low-power");
    cfg_wr = 1'b0; cfg_wdata = '0;
    @(posedge clk); #1; line_state = 2'b11;
    #(PERIOD/4);
    tests++;
    if (bus_out[1:0] !== 2'b11) begin
      fails++;
      $display("FAIL R5 combinational linestate: got %b expected 11", bus_out[1:0]);
    end
    @(negedge clk);
    stp = 1'b1; step("R2 R4 stp exits low-power");
    stp = 1'b0; irq_pending = 1'b0; line_state = '0; step("R8 back in normal");

    cfg_wr = 1'b1; cfg_wdata = 8'h09; step("R3 R4 enter six-pin with keep");
    cfg_wr = 1'b0; cfg_wdata = '0; bus_in = 8'h05; rx_dp = 1'b1; step("R6 R9 six-pin settled");
    bus_in = 8'h03; rx_dm = 1'b1; rx_rcv = 1'b1; irq_pending = 1'b1; step("R6 receive outputs");
    bus_in = 8'h02; rx_dp = 1'b0; step("R6 data without enable");
    cfg_wr = 1'b1; cfg_wdata = 8'h02; lp_req = 1'b1; step("R3 write and lp_req ignored in six-pin");
    cfg_wr = 1'b0; cfg_wdata = '0; lp_req = 1'b0; stp = 1'b1; step("R2 R4 stp exits six-pin");
    stp = 1'b0; bus_in = '0; step("R8 normal after six-pin");

    cfg_wr = 1'b1; cfg_wdata = 8'h03; step("R3 both bits pick six-pin");
    cfg_wr = 1'b0; cfg_wdata = '0; step("R9 clock stopped without keep");
    stp = 1'b1; step("R2 exit");
    stp = 1'b0; cfg_wr = 1'b1; cfg_wdata = 8'h08; step("R3 write without mode bits");
    cfg_wr = 1'b1; cfg_wdata = 8'h0A; lp_req = 1'b1; step("R3 write beats lp_req, enter three-pin");
    cfg_wr = 1'b0; cfg_wdata = '0; lp_req = 1'b0; rx_rcv = 1'b1; bus_in = 8'h00; step("R7 three-pin receive on pin 1");
    bus_in = 8'h03; step("R7 three-pin transmit, pin 1 released");
    bus_in = 8'h06; rx_rcv = 1'b0; step("R7 data gated, se0 passed");
    bus_in = 8'h01; irq_pending = 1'b0; step("R7 R9 keep clock");
    stp = 1'b1; step("R2 R4 stp exits three-pin");
    stp = 1'b0; bus_in = '0; step("R8 final normal");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule